// File: doc/BRIEF.md
# Multi-Word Mailbox Message Streamer

This block moves variable-length messages between a valid/ready word stream and a mailbox that offers a small, fixed set of data registers in each direction. Each register has its own flag: "empty" on the transmit side and "full" on the receive side. Word `i` of a message always uses register `i mod N`, where N is the number of registers. The length of a message comes from an 8-bit size field, bits 15:8, of its first word (the header). That length counts the header itself, in 32-bit words.

On transmit, the block writes the header and the words that fit in the registers without looking at the flags. Each later word waits until its register reports empty. On receive, the block reads the header from register 0 as soon as that register is full. It then collects each further word once that word's register reports full.

While a message is being collected, the interrupt enable for receive register 0 is held low. A header whose length is larger than the limit for the current mode aborts the message. A flag wait that lasts longer than a programmable number of cycles also aborts the message. Every transfer, whether it succeeds or fails, ends with a one-cycle done pulse that carries an error code.

Top module: `mbs_streamer`

## Requirements
- R1: Word i of a message (header is i = 0) is written to transmit register index i mod NUM_REGS and read from receive register index i mod NUM_REGS; data passes through unchanged in order.
- R2: On transmit, the first min(L, NUM_REGS) words of a message are accepted and written on consecutive cycles when the source offers them, even when every transmit-empty flag is 0; the header is accepted in idle at any time.
- R3: On transmit, a word with index i >= NUM_REGS is accepted and written only in a cycle where transmit-empty flag i mod NUM_REGS is 1.
- R4: The message length L is header bits 15:8, counted in 32-bit words including the header; L of 0 or 1 means a header-only message.
- R5: On receive, the header is read from register 0 only while receive-full flag 0 is 1, and every later word i is read only while receive-full flag i mod NUM_REGS is 1.
- R6: With largeMode = 0, a header with L > 31 ends the message with error code 1 and error index 0, and no further word is moved. On transmit, that header is not written. On receive, that header is delivered. With largeMode = 1, any 8-bit length up to 255 is accepted.
- R7: rxIrqEn0 is 1 in idle and in the done cycle. It is 0 from the cycle after a multi-word header is read until the receive transfer ends.
- R8: When the flag a pending word waits on stays inactive for timeoutLimit consecutive cycles, the next cycle brings done with error code 2 and error index equal to the stalled word's index. A timeoutLimit of 0 disables the timeout.
- R9: txDone/rxDone is a one-cycle pulse in the cycle after the last word moves, or after the header for an oversize message. The error code is 0 on success and 0 whenever done is low; the error index is 0 unless the code is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| largeMode | input | 1 | 1 selects the 255-word length limit, 0 the 31-word limit |
| timeoutLimit | input | TMO_W | Stall cycles before abort; 0 disables |
| txWordValid | input | 1 | Transmit stream word valid |
| txWordReady | output | 1 | Transmit stream word accepted this cycle |
| txWord | input | DATA_W | Transmit stream word |
| mbTxWrite | output | 1 | Write strobe to a transmit register |
| mbTxIdx | output | SLOT_W | Transmit register index |
| mbTxData | output | DATA_W | Transmit register write data |
| mbTxEmpty | input | NUM_REGS | Per-register transmit-empty flags |
| mbRxFull | input | NUM_REGS | Per-register receive-full flags |
| mbRxRead | output | 1 | Read strobe to a receive register |
| mbRxIdx | output | SLOT_W | Receive register index |
| mbRxData | input | DATA_W | Data of the receive register at mbRxIdx |
| rxWordValid | output | 1 | Receive stream word valid |
| rxWordReady | input | 1 | Receive stream sink ready |
| rxWord | output | DATA_W | Receive stream word |
| rxIrqEn0 | output | 1 | Interrupt enable for receive register 0 |
| txDone | output | 1 | Transmit transfer end pulse |
| txErr | output | 2 | Transmit error code (0 none, 1 oversize, 2 timeout) |
| txErrIdx | output | LEN_W | Stalled transmit word index on timeout |
| rxDone | output | 1 | Receive transfer end pulse |
| rxErr | output | 2 | Receive error code (0 none, 1 oversize, 2 timeout) |
| rxErrIdx | output | LEN_W | Stalled receive word index on timeout |

## Verification
The bench targets the point where transmit moves from the unchecked burst into flag-gated writes. It holds every empty flag low so that a design which checks flags too early stalls the header burst, and a design which checks too late overwrites an undrained register. An exact stall-to-done cycle count exposes an off-by-one in the timeout counter, and the reported word index shows whether the design counts from the header. Oversize headers in both modes, header-only lengths 0 and 1, and the receive path's interrupt-enable window catch a design that leaks a write after an abort or re-enables the interrupt before collection is over.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_OVERSIZE = 2'd1,
    ERR_TIMEOUT  = 2'd2
  } errCode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } xferState_e;

  // strobes from a direction's FSM to its lane datapath
  typedef struct packed {
    logic start;    // header accepted: load length, index -> 1
    logic step;     // current word moved: index + 1
    logic waiting;  // in body phase: stalls count toward timeout
    logic finish;   // done cycle: index back to 0
  } laneStrobe_t;
endpackage

// File: rtl/mbs_lane.sv
module mbs_lane
  import mbs_pkg::*;
#(
  parameter int NUM_REGS   = 4,
  parameter int LEN_W      = 8,
  parameter int TMO_W      = 16,
  parameter int SMALL_MAX  = 31,
  parameter int LARGE_MAX  = 255,
  parameter bit WAIVE_HEAD = 1'b1,
  localparam int SLOT_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       stb,
  input  logic [LEN_W-1:0]  hdrLen,
  input  logic [NUM_REGS-1:0] flags,
  input  logic [TMO_W-1:0]  timeoutLimit,
  input  logic              largeMode,
  output logic [LEN_W-1:0]  idx,
  output logic [SLOT_W-1:0] slot,
  output logic              mayMove,
  output logic              hdrOver,
  output logic              hdrSingle,
  output logic              lastWord,
  output logic              tmoHit
);
  logic [LEN_W-1:0] idxQ, lenQ;
  logic [TMO_W-1:0] stallQ;
  logic             flagOk;

  assign idx       = idxQ;
  assign slot      = idxQ[SLOT_W-1:0];
  assign flagOk    = flags[slot];
  assign hdrOver   = largeMode ? (int'(hdrLen) > LARGE_MAX) : (int'(hdrLen) > SMALL_MAX);
  assign hdrSingle = hdrLen < LEN_W'(2);
  assign lastWord  = (idxQ + LEN_W'(1)) == lenQ;

  // variant: transmit waives the flag for the first NUM_REGS words
  generate
    if (WAIVE_HEAD) begin : g_waive
      assign mayMove = flagOk || (int'(idxQ) < NUM_REGS);
    end else begin : g_strict
      assign mayMove = flagOk;
    end
  endgenerate

  assign tmoHit = stb.waiting && !mayMove && (timeoutLimit != '0)
                  && (stallQ == timeoutLimit - TMO_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ   <= '0;
      lenQ   <= '0;
      stallQ <= '0;
    end else if (stb.start) begin
      idxQ   <= LEN_W'(1);
      lenQ   <= hdrLen;
      stallQ <= '0;
    end else if (stb.finish) begin
      idxQ   <= '0;
      stallQ <= '0;
    end else if (stb.step) begin
      idxQ   <= idxQ + LEN_W'(1);
      stallQ <= '0;
    end else if (stb.waiting && !mayMove) begin
      stallQ <= stallQ + TMO_W'(1);
    end
  end
endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        txWordValid,
  input  logic        rxWordReady,
  input  logic        txMayMove,
  input  logic        txHdrOver,
  input  logic        txHdrSingle,
  input  logic        txLast,
  input  logic        txTmo,
  input  logic        rxMayMove,
  input  logic        rxHdrOver,
  input  logic        rxHdrSingle,
  input  logic        rxLast,
  input  logic        rxTmo,
  output laneStrobe_t txStb,
  output laneStrobe_t rxStb,
  output logic        txWordReady,
  output logic        mbTxWrite,
  output logic        rxWordValid,
  output logic        mbRxRead,
  output logic        rxIrqEn0,
  output logic        txDone,
  output logic        rxDone,
  output errCode_e    txErr,
  output errCode_e    rxErr
);
  xferState_e txState, txNext, rxState, rxNext;
  errCode_e   txErrQ, txErrNext, rxErrQ, rxErrNext;

  always_comb begin
    txNext = txState; txErrNext = txErrQ; txStb = '0;
    txWordReady = 1'b0; mbTxWrite = 1'b0;
    case (txState)
      ST_IDLE: begin
        txWordReady = 1'b1;
        if (txWordValid) begin
          txStb.start = 1'b1;
          mbTxWrite   = !txHdrOver;
          txErrNext   = txHdrOver ? ERR_OVERSIZE : ERR_NONE;
          txNext      = (txHdrOver || txHdrSingle) ? ST_DONE : ST_XFER;
        end
      end
      ST_XFER: begin
        txStb.waiting = 1'b1;
        txWordReady   = txMayMove;
        mbTxWrite     = txWordValid && txMayMove;
        txStb.step    = mbTxWrite;
        if (mbTxWrite && txLast) txNext = ST_DONE;
        else if (txTmo) begin txNext = ST_DONE; txErrNext = ERR_TIMEOUT; end
      end
      ST_DONE: begin txStb.finish = 1'b1; txNext = ST_IDLE; end
      default: txNext = ST_IDLE;
    endcase
  end

  always_comb begin
    rxNext = rxState; rxErrNext = rxErrQ; rxStb = '0;
    rxWordValid = 1'b0; mbRxRead = 1'b0;
    case (rxState)
      ST_IDLE: begin
        rxWordValid = rxMayMove;
        mbRxRead    = rxMayMove && rxWordReady;
        if (mbRxRead) begin
          rxStb.start = 1'b1;
          rxErrNext   = rxHdrOver ? ERR_OVERSIZE : ERR_NONE;
          rxNext      = (rxHdrOver || rxHdrSingle) ? ST_DONE : ST_XFER;
        end
      end
      ST_XFER: begin
        rxStb.waiting = 1'b1;
        rxWordValid   = rxMayMove;
        mbRxRead      = rxMayMove && rxWordReady;
        rxStb.step    = mbRxRead;
        if (mbRxRead && rxLast) rxNext = ST_DONE;
        else if (rxTmo) begin rxNext = ST_DONE; rxErrNext = ERR_TIMEOUT; end
      end
      ST_DONE: begin rxStb.finish = 1'b1; rxNext = ST_IDLE; end
      default: rxNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= ST_IDLE; rxState <= ST_IDLE;
      txErrQ  <= ERR_NONE; rxErrQ <= ERR_NONE;
    end else begin
      txState <= txNext; rxState <= rxNext;
      txErrQ  <= txErrNext; rxErrQ <= rxErrNext;
    end
  end

  assign txDone   = txState == ST_DONE;
  assign rxDone   = rxState == ST_DONE;
  assign txErr    = txDone ? txErrQ : ERR_NONE;
  assign rxErr    = rxDone ? rxErrQ : ERR_NONE;
  assign rxIrqEn0 = rxState != ST_XFER;
endmodule

// File: rtl/mbs_streamer.sv
module mbs_streamer
  import mbs_pkg::*;
#(
  parameter int NUM_REGS  = 4,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int LEN_LSB   = 8,
  parameter int TMO_W     = 16,
  parameter int SMALL_MAX = 31,
  parameter int LARGE_MAX = 255,
  localparam int SLOT_W   = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                largeMode,
  input  logic [TMO_W-1:0]    timeoutLimit,
  input  logic                txWordValid,
  output logic                txWordReady,
  input  logic [DATA_W-1:0]   txWord,
  output logic                mbTxWrite,
  output logic [SLOT_W-1:0]   mbTxIdx,
  output logic [DATA_W-1:0]   mbTxData,
  input  logic [NUM_REGS-1:0] mbTxEmpty,
  input  logic [NUM_REGS-1:0] mbRxFull,
  output logic                mbRxRead,
  output logic [SLOT_W-1:0]   mbRxIdx,
  input  logic [DATA_W-1:0]   mbRxData,
  output logic                rxWordValid,
  input  logic                rxWordReady,
  output logic [DATA_W-1:0]   rxWord,
  output logic                rxIrqEn0,
  output logic                txDone,
  output logic [1:0]          txErr,
  output logic [LEN_W-1:0]    txErrIdx,
  output logic                rxDone,
  output logic [1:0]          rxErr,
  output logic [LEN_W-1:0]    rxErrIdx
);
  laneStrobe_t      txStb, rxStb;
  logic [LEN_W-1:0] txIdx, rxIdx;
  logic txMayMove, txHdrOver, txHdrSingle, txLast, txTmo;
  logic rxMayMove, rxHdrOver, rxHdrSingle, rxLast, rxTmo;
  errCode_e txErrE, rxErrE;

  mbs_lane #(.NUM_REGS(NUM_REGS), .LEN_W(LEN_W), .TMO_W(TMO_W), .SMALL_MAX(SMALL_MAX),
             .LARGE_MAX(LARGE_MAX), .WAIVE_HEAD(1'b1)) u_txLane (
    .clk(clk), .rstN(rstN), .stb(txStb), .hdrLen(txWord[LEN_LSB +: LEN_W]),
    .flags(mbTxEmpty), .timeoutLimit(timeoutLimit), .largeMode(largeMode),
    .idx(txIdx), .slot(mbTxIdx), .mayMove(txMayMove), .hdrOver(txHdrOver),
    .hdrSingle(txHdrSingle), .lastWord(txLast), .tmoHit(txTmo));

  mbs_lane #(.NUM_REGS(NUM_REGS), .LEN_W(LEN_W), .TMO_W(TMO_W), .SMALL_MAX(SMALL_MAX),
             .LARGE_MAX(LARGE_MAX), .WAIVE_HEAD(1'b0)) u_rxLane (
    .clk(clk), .rstN(rstN), .stb(rxStb), .hdrLen(mbRxData[LEN_LSB +: LEN_W]),
    .flags(mbRxFull), .timeoutLimit(timeoutLimit), .largeMode(largeMode),
    .idx(rxIdx), .slot(mbRxIdx), .mayMove(rxMayMove), .hdrOver(rxHdrOver),
    .hdrSingle(rxHdrSingle), .lastWord(rxLast), .tmoHit(rxTmo));

  mbs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txWordValid(txWordValid), .rxWordReady(rxWordReady),
    .txMayMove(txMayMove), .txHdrOver(txHdrOver), .txHdrSingle(txHdrSingle),
    .txLast(txLast), .txTmo(txTmo), .rxMayMove(rxMayMove), .rxHdrOver(rxHdrOver),
    .rxHdrSingle(rxHdrSingle), .rxLast(rxLast), .rxTmo(rxTmo),
    .txStb(txStb), .rxStb(rxStb), .txWordReady(txWordReady), .mbTxWrite(mbTxWrite),
    .rxWordValid(rxWordValid), .mbRxRead(mbRxRead), .rxIrqEn0(rxIrqEn0),
    .txDone(txDone), .rxDone(rxDone), .txErr(txErrE), .rxErr(rxErrE));

  assign mbTxData = txWord;
  assign rxWord   = mbRxData;
  assign txErr    = txErrE;
  assign rxErr    = rxErrE;
  assign txErrIdx = (txErrE == ERR_TIMEOUT) ? txIdx : '0;
  assign rxErrIdx = (rxErrE == ERR_TIMEOUT) ? rxIdx : '0;
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int NUM_REGS = 4,
  parameter int LEN_W    = 8,
  localparam int SLOT_W  = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                mbTxWrite,
  input logic [SLOT_W-1:0]   mbTxIdx,
  input logic [NUM_REGS-1:0] mbTxEmpty,
  input logic                mbRxRead,
  input logic [SLOT_W-1:0]   mbRxIdx,
  input logic [NUM_REGS-1:0] mbRxFull,
  input logic                rxIrqEn0,
  input logic                txDone,
  input logic                rxDone,
  input logic [1:0]          txErr,
  input logic [1:0]          rxErr
);
  logic [LEN_W-1:0] txCnt, rxCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt <= '0;
      rxCnt <= '0;
    end else begin
      if (txDone) txCnt <= '0;
      else if (mbTxWrite) txCnt <= txCnt + LEN_W'(1);
      if (rxDone) rxCnt <= '0;
      else if (mbRxRead) rxCnt <= rxCnt + LEN_W'(1);
    end
  end

  AST_TX_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    mbTxWrite |-> mbTxIdx == txCnt[SLOT_W-1:0]); // R1
  AST_RX_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    mbRxRead |-> mbRxIdx == rxCnt[SLOT_W-1:0]); // R1
  AST_TX_GATED_BY_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (mbTxWrite && int'(txCnt) >= NUM_REGS) |-> mbTxEmpty[mbTxIdx]); // R3
  AST_RX_GATED_BY_FULL: assert property (@(posedge clk) disable iff (!rstN)
    mbRxRead |-> mbRxFull[mbRxIdx]); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (rxCnt != '0 && !rxDone) |-> !rxIrqEn0); // R7
  AST_TX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone); // R9
  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!txDone && !rxDone) |-> (txErr == 2'd0 && rxErr == 2'd0)); // R9
endmodule

bind mbs_streamer mbs_checker #(.NUM_REGS(NUM_REGS), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .mbTxWrite(mbTxWrite), .mbTxIdx(mbTxIdx),
  .mbTxEmpty(mbTxEmpty), .mbRxRead(mbRxRead), .mbRxIdx(mbRxIdx),
  .mbRxFull(mbRxFull), .rxIrqEn0(rxIrqEn0), .txDone(txDone), .rxDone(rxDone),
  .txErr(txErr), .rxErr(rxErr));

// File: tb/sim_mbs_streamer.sv
module sim_mbs_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int SW = $clog2(N);

  logic clk = 1'b0, rstN = 1'b0;
  logic largeMode = 1'b0;
  logic [15:0] timeoutLimit = 16'd1000;
  logic txWordValid = 1'b0, txWordReady;
  logic [31:0] txWord = '0;
  logic mbTxWrite; logic [SW-1:0] mbTxIdx; logic [31:0] mbTxData;
  logic [N-1:0] txEmptyB = '1;
  logic [N-1:0] rxFullB = '0;
  logic mbRxRead; logic [SW-1:0] mbRxIdx; logic [31:0] mbRxData;
  logic rxWordValid; logic rxWordReady = 1'b1; logic [31:0] rxWord;
  logic rxIrqEn0, txDone, rxDone;
  logic [1:0] txErr, rxErr; logic [7:0] txErrIdx, rxErrIdx;
  logic [31:0] rxMb [N];

  int checks = 0, errors = 0, cyc = 0;
  bit drainEn = 1'b1, drainTick = 1'b0, rxSendEn = 1'b1;
  int drainPtr = 0, rxSendPtr = 0;
  int txExpIdx[$], txExpDat[$], rxExpIdx[$], rxExpDat[$];
  logic [31:0] rxSendQ[$];
  int txWrN = 0, txWrFirst = 0, txWrLast = 0, txDoneN = 0, txLastErr = 0, txLastIdx = 0, txDoneCyc = 0;
  int rxRdN = 0, rxDoneN = 0, rxLastErr = 0, rxLastIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign mbRxData = rxMb[mbRxIdx];

  mbs_streamer u0 (
    .clk(clk), .rstN(rstN), .largeMode(largeMode), .timeoutLimit(timeoutLimit),
    .txWordValid(txWordValid), .txWordReady(txWordReady), .txWord(txWord),
    .mbTxWrite(mbTxWrite), .mbTxIdx(mbTxIdx), .mbTxData(mbTxData), .mbTxEmpty(txEmptyB),
    .mbRxFull(rxFullB), .mbRxRead(mbRxRead), .mbRxIdx(mbRxIdx), .mbRxData(mbRxData),
    .rxWordValid(rxWordValid), .rxWordReady(rxWordReady), .rxWord(rxWord),
    .rxIrqEn0(rxIrqEn0), .txDone(txDone), .txErr(txErr), .txErrIdx(txErrIdx),
    .rxDone(rxDone), .rxErr(rxErr), .rxErrIdx(rxErrIdx));

  // mailbox model: remote side drains transmit registers, fills receive registers
  always @(posedge clk) begin
    drainTick <= ~drainTick;
    if (drainEn && drainTick && !txEmptyB[drainPtr]) begin
      txEmptyB[drainPtr] <= 1'b1;
      drainPtr <= (drainPtr + 1) % N;
    end
    if (mbTxWrite) txEmptyB[mbTxIdx] <= 1'b0;
    if (mbRxRead) rxFullB[mbRxIdx] <= 1'b0;
    if (rxSendEn && rxSendQ.size() > 0 && !rxFullB[rxSendPtr]) begin
      rxMb[rxSendPtr] <= rxSendQ.pop_front();
      rxFullB[rxSendPtr] <= 1'b1;
      rxSendPtr <= (rxSendPtr + 1) % N;
    end
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: scoreboard compare as the design produces words
  always @(negedge clk) begin
    if (rstN) begin
      if (mbTxWrite) begin
        if (txExpIdx.size() == 0) check(1'b0, "R1", "unexpected tx write", int'(mbTxIdx), -1);
        else begin
          int ei, ed;
          ei = txExpIdx.pop_front(); ed = txExpDat.pop_front();
          check(int'(mbTxIdx) == ei, "R1", "tx register index", int'(mbTxIdx), ei);
          check(mbTxData == ed, "R1", "tx data", mbTxData, ed);
        end
        if (txWrN >= N) check(txEmptyB[mbTxIdx], "R3", "tx write into non-empty register", 0, 1);
        if (txWrN == 0) txWrFirst = cyc;
        txWrLast = cyc;
        txWrN++;
      end
      if (txDone) begin
        txDoneN++; txLastErr = txErr; txLastIdx = txErrIdx; txDoneCyc = cyc; txWrN = 0;
      end
      if (mbRxRead) begin
        if (rxExpIdx.size() == 0) check(1'b0, "R5", "unexpected rx read", int'(mbRxIdx), -1);
        else begin
          int ei, ed;
          ei = rxExpIdx.pop_front(); ed = rxExpDat.pop_front();
          check(int'(mbRxIdx) == ei, "R1", "rx register index", int'(mbRxIdx), ei);
          check(rxWord == ed, "R1", "rx data", rxWord, ed);
        end
        check(rxFullB[mbRxIdx], "R5", "rx read of non-full register", 0, 1);
        rxRdN++;
      end
      if (rxDone) begin
        rxDoneN++; rxLastErr = rxErr; rxLastIdx = rxErrIdx; rxRdN = 0;
      end
    end
  end

  function automatic logic [31:0] wordOf(input int k, input int len, input int seed);
    if (k == 0) return {16'hC0DE, 8'(len), 8'h5A};
    return 32'(seed + k);
  endfunction

  task automatic txSend(input int len, input int seed, input int nDrive, input int nExpect);
    for (int k = 0; k < nExpect; k++) begin
      txExpIdx.push_back(k % N); txExpDat.push_back(wordOf(k, len, seed));
    end
    for (int k = 0; k < nDrive; k++) begin
      bit acc, dn;
      txWord = wordOf(k, len, seed); txWordValid = 1'b1;
      do begin
        @(negedge clk); acc = txWordReady; dn = txDone;
        @(posedge clk); #1;
      end while (!acc && !dn);
      if (!acc) break;
    end
    txWordValid = 1'b0;
  endtask

  task automatic rxLoad(input int len, input int seed, input int nSend, input int nExpect);
    for (int k = 0; k < nSend; k++) rxSendQ.push_back(wordOf(k, len, seed));
    for (int k = 0; k < nExpect; k++) begin
      rxExpIdx.push_back(k % N); rxExpDat.push_back(wordOf(k, len, seed));
    end
  endtask

  task automatic waitTx(input int prev);
    for (int i = 0; i < 5000 && txDoneN <= prev; i++) @(posedge clk);
    #1;
  endtask

  task automatic waitRx(input int prev);
    for (int i = 0; i < 5000 && rxDoneN <= prev; i++) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(txWordReady == 1'b1, "R2", "reset: idle accepts header", txWordReady, 1);
    check(rxWordValid == 1'b0, "R5", "reset: no rx word", rxWordValid, 0);
    check(rxIrqEn0 == 1'b1, "R7", "reset: irq enable", rxIrqEn0, 1);
    check(txDone == 1'b0 && txErr == 2'd0, "R9", "reset: tx done quiet", txDone, 0);
    @(posedge clk); #1;

    // short transmit, fewer words than registers
    p = txDoneN; txSend(3, 100, 3, 3); waitTx(p);
    check(txLastErr == 0, "R9", "tx len3 error code", txLastErr, 0);
    check(txExpIdx.size() == 0, "R1", "tx len3 words missing", txExpIdx.size(), 0);

    // long transmit through flag-gated reuse
    p = txDoneN; txSend(10, 200, 10, 10); waitTx(p);
    check(txLastErr == 0, "R9", "tx len10 error code", txLastErr, 0);
    check(txExpIdx.size() == 0, "R3", "tx len10 words missing", txExpIdx.size(), 0);

    // header-only lengths
    p = txDoneN; txSend(0, 300, 1, 1); waitTx(p);
    check(txLastErr == 0 && txExpIdx.size() == 0, "R4", "tx len0 header only", txLastErr, 0);
    p = txDoneN; txSend(1, 310, 1, 1); waitTx(p);
    check(txLastErr == 0 && txExpIdx.size() == 0, "R4", "tx len1 header only", txLastErr, 0);

    // burst without flags, then timeout on word 4
    repeat (4) @(posedge clk); #1;
    drainEn = 1'b0; txEmptyB = '0; timeoutLimit = 16'd20;
    p = txDoneN; txSend(6, 400, 6, 4); waitTx(p);
    check(txWrLast - txWrFirst == 3, "R2", "burst of 4 back to back", txWrLast - txWrFirst, 3);
    check(txLastErr == 2, "R8", "tx timeout code", txLastErr, 2);
    check(txLastIdx == 4, "R8", "tx stalled index", txLastIdx, 4);
    check(txDoneCyc - txWrLast == 21, "R8", "tx timeout cycle", txDoneCyc - txWrLast, 21);
    check(txExpIdx.size() == 0, "R2", "burst words missing", txExpIdx.size(), 0);
    txEmptyB = '1; drainEn = 1'b1; timeoutLimit = 16'd1000;

    // oversize in small mode, then accepted in large mode
    p = txDoneN; txSend(40, 500, 1, 0); waitTx(p);
    check(txLastErr == 1, "R6", "tx oversize code", txLastErr, 1);
    check(txLastIdx == 0, "R6", "tx oversize index", txLastIdx, 0);
    largeMode = 1'b1;
    p = txDoneN; txSend(40, 600, 40, 40); waitTx(p);
    check(txLastErr == 0 && txExpIdx.size() == 0, "R6", "tx len40 large mode", txLastErr, 0);
    largeMode = 1'b0;

    // receive, full message
    rxSendPtr = 0;
    p = rxDoneN; rxLoad(7, 700, 7, 7); waitRx(p);
    check(rxLastErr == 0, "R4", "rx len7 error code", rxLastErr, 0);
    check(rxExpIdx.size() == 0, "R5", "rx len7 words missing", rxExpIdx.size(), 0);

    // irq enable window: header only first, rest later
    rxSendPtr = 0;
    p = rxDoneN; rxLoad(5, 800, 1, 5);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(rxIrqEn0 == 1'b0, "R7", "irq masked during collection", rxIrqEn0, 0);
    check(rxWordValid == 1'b0, "R5", "no word while register 1 empty", rxWordValid, 0);
    @(posedge clk); #1;
    for (int k = 1; k < 5; k++) rxSendQ.push_back(wordOf(k, 5, 800));
    waitRx(p);
    @(negedge clk);
    check(rxIrqEn0 == 1'b1, "R7", "irq restored after done", rxIrqEn0, 1);
    check(rxLastErr == 0 && rxExpIdx.size() == 0, "R5", "rx len5 delayed", rxLastErr, 0);
    @(posedge clk); #1;

    // receive timeout after 3 of 6 words
    timeoutLimit = 16'd15; rxSendPtr = 0;
    p = rxDoneN; rxLoad(6, 900, 3, 3); waitRx(p);
    check(rxLastErr == 2, "R8", "rx timeout code", rxLastErr, 2);
    check(rxLastIdx == 3, "R8", "rx stalled index", rxLastIdx, 3);
    timeoutLimit = 16'd1000;

    // receive oversize: header delivered, nothing more
    rxSendPtr = 0;
    p = rxDoneN; rxLoad(50, 1000, 1, 1); waitRx(p);
    check(rxLastErr == 1 && rxLastIdx == 0, "R6", "rx oversize code", rxLastErr, 1);
    check(rxExpIdx.size() == 0, "R6", "rx oversize header", rxExpIdx.size(), 0);

    repeat (5) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule